// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability and Request Generator

This block is the endpoint-side logic for message-signalled interrupts. It presents a small window of configuration space to the host. The window holds a capability pointer and one capability node with a control word, a 64-bit message address and a 16-bit message data value. The host finds the node by following the pointer, then programs the address and data and sets the enable bit. Configuration accesses use a plain request interface with per-byte write enables. Reads return their data on the cycle after the request.

Local interrupt sources raise one-cycle pulses on `irq_src`. Each pulse latches a pending bit for its source. While messaging is enabled, the block turns the lowest-numbered pending source into a single memory-write request on a valid/ready port. The request carries the programmed address. Its payload is the programmed data value plus the source index, masked to the number of vectors the host granted. While messaging is disabled, no request leaves the block and pending sources drive the level-sensitive legacy line `intx_o` instead.

`rst_n` is an asynchronous active-low reset whose release is expected to be already synchronised to `clk` by the surrounding reset tree.

Top module: `msi_cap_gen`

## Requirements
- R1: A read of byte offset 0x34 returns the node's offset `CAP_PTR` (default 0x50) in bits [7:0] with all other bits zero. A read of any offset outside 0x34 and the four node words returns zero. Read data appears on `cfg_rdata` the cycle after the request and holds until the next read.
- R2: Node word 0 at `CAP_PTR` reads as follows: capability ID `CAP_ID` (default 0x05) in [7:0], next pointer 0x00 in [15:8], enable in [16], vectors-capable log2 (clog2 of `NUM_SRC`, read-only) in [19:17], vectors-granted log2 in [22:20], a constant 1 in [23] marking 64-bit address support, and zero in [31:24].
- R3: Writes honour `cfg_be` per byte lane. Address low is at node+4 and reads bits [1:0] as zero. Address high is at node+8. Data is at node+0xC in [15:0], with [31:16] reading zero. Enable and vectors-granted are written through lane 2 of node word 0.
- R4: After reset, every programmable field reads zero, `req_valid` is low and `intx_o` is low.
- R5: When messaging is enabled and a source is pending, a request is raised. `req_addr` equals {address high, address low}. `req_data` is {16'h0, data + v}, where the sum wraps at 16 bits and v is the source index masked as described in R7.
- R6: Pending sources are issued one at a time, lowest index first. Each latched pulse produces exactly one request. A source's pending bit clears when its request completes with `req_valid` and `req_ready` both high.
- R7: With n = min(vectors-granted, vectors-capable), v is the source index with all bits above n-1 cleared. Sources that differ only above bit n-1 therefore send the same payload.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_data` stay unchanged. A newly pending source of higher priority does not replace the request in flight.
- R9: While enable is 0, no request is raised and pending bits are kept, and `intx_o` is high exactly when at least one source is pending. While enable is 1, `intx_o` is low.
- R10: A pulse on `irq_clr[k]` drops source k's pending bit, so that source sends no message and no longer contributes to `intx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Configuration access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 8 | Configuration byte offset (bits [1:0] ignored) |
| cfg_be | input | 4 | Byte-lane write enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, registered |
| irq_src | input | NUM_SRC | Interrupt event pulses, one per source |
| irq_clr | input | NUM_SRC | Drops the pending bit of a source |
| req_valid | output | 1 | Memory-write request valid |
| req_ready | input | 1 | Memory-write request accepted |
| req_addr | output | 64 | Write address |
| req_data | output | 32 | Write payload |
| intx_o | output | 1 | Legacy level interrupt |

## Verification
A table of six cases drives the main path. Each case sets a different vectors-granted value, data word and set of simultaneous sources. Full four-vector grants with all sources firing show that payloads are distinct and come out in ascending index order. A grant of zero, and a grant of one with sources that differ only in high bits, show that masked indices collide onto the same payload. A grant larger than the capability shows the clamp, and a data word near 0xFFFF shows the 16-bit wrap. Directed tests cover the reset state, the header and pointer reads, per-lane writes, a held-off request with a higher-priority source arriving behind it, and a clear that lands while messaging is disabled.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

  localparam logic [7:0] CFG_CAPPTR_OFS = 8'h34;

  typedef struct packed {
    logic        en;
    logic [2:0]  mme;
    logic [63:0] addr;
    logic [15:0] data;
  } msi_cfg_t;

  // Number of low data bits the device may modify: the grant clamped to the capability.
  function automatic logic [2:0] eff_bits(input logic [2:0] granted, input logic [2:0] capable);
    eff_bits = (granted > capable) ? capable : granted;
  endfunction

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_cap_pkg::*;
#(
  parameter logic [7:0] CAP_PTR = 8'h50,
  parameter logic [7:0] CAP_ID  = 8'h05,
  parameter int unsigned MMC    = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_req,
  input  logic           cfg_we,
  input  logic [7:0]     cfg_addr,
  input  logic [3:0]     cfg_be,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  output msi_cfg_t       cfg_o
);

  localparam logic [5:0] W_PTR = CFG_CAPPTR_OFS[7:2];
  localparam logic [5:0] W_CTL = CAP_PTR[7:2];
  localparam logic [5:0] W_ALO = CAP_PTR[7:2] + 6'd1;
  localparam logic [5:0] W_AHI = CAP_PTR[7:2] + 6'd2;
  localparam logic [5:0] W_DAT = CAP_PTR[7:2] + 6'd3;
  localparam logic [2:0] MMC_F = 3'(MMC);

  msi_cfg_t    cfg_q, cfg_d;
  logic [31:0] rdata_q, rdata_d;
  logic [31:0] rd_word;
  logic [5:0]  widx;
  logic        wr_en, rd_en;
  logic        unused_lsb;

  assign widx       = cfg_addr[7:2];
  assign unused_lsb = ^cfg_addr[1:0];
  assign wr_en      = cfg_req & cfg_we;
  assign rd_en      = cfg_req & ~cfg_we;

  always_comb begin
    rd_word = '0;
    if (widx == W_PTR) begin
      rd_word[7:0] = CAP_PTR;
    end else if (widx == W_CTL) begin
      rd_word[7:0]   = CAP_ID;
      rd_word[15:8]  = 8'h00;
      rd_word[16]    = cfg_q.en;
      rd_word[19:17] = MMC_F;
      rd_word[22:20] = cfg_q.mme;
      rd_word[23]    = 1'b1;
    end else if (widx == W_ALO) begin
      rd_word = {cfg_q.addr[31:2], 2'b00};
    end else if (widx == W_AHI) begin
      rd_word = cfg_q.addr[63:32];
    end else if (widx == W_DAT) begin
      rd_word[15:0] = cfg_q.data;
    end
  end

  always_comb begin
    cfg_d   = cfg_q;
    rdata_d = rdata_q;
    if (wr_en) begin
      if (widx == W_CTL && cfg_be[2]) begin
        cfg_d.en  = cfg_wdata[16];
        cfg_d.mme = cfg_wdata[22:20];
      end
      if (widx == W_ALO) begin
        for (int b = 0; b < 4; b++) begin
          if (cfg_be[b]) cfg_d.addr[8*b +: 8] = cfg_wdata[8*b +: 8];
        end
        cfg_d.addr[1:0] = 2'b00;
      end
      if (widx == W_AHI) begin
        for (int b = 0; b < 4; b++) begin
          if (cfg_be[b]) cfg_d.addr[32+8*b +: 8] = cfg_wdata[8*b +: 8];
        end
      end
      if (widx == W_DAT) begin
        for (int b = 0; b < 2; b++) begin
          if (cfg_be[b]) cfg_d.data[8*b +: 8] = cfg_wdata[8*b +: 8];
        end
      end
    end
    if (rd_en) rdata_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      rdata_q <= '0;
    end else begin
      cfg_q   <= cfg_d;
      rdata_q <= rdata_d;
    end
  end

  assign cfg_o     = cfg_q;
  assign cfg_rdata = rdata_q;

endmodule

// File: rtl/msi_pend_arb.sv
module msi_pend_arb #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic [NUM_SRC-1:0] clr,
  input  logic [NUM_SRC-1:0] done_vec,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               pick_vld,
  output logic [IDX_W-1:0]   pick_idx
);

  logic [NUM_SRC-1:0] pend_q, pend_d;

  // A new pulse in the same cycle as a clear or completion wins: it is a fresh event.
  always_comb begin
    pend_d = (pend_q & ~clr & ~done_vec) | src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // Fixed priority, lowest index wins: scan from the top so the last hit is the lowest.
  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        pick_vld = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/msi_req_gen.sv
module msi_req_gen
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned MMC     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  msi_cfg_t           cfg,
  input  logic               pick_vld,
  input  logic [IDX_W-1:0]   pick_idx,
  input  logic               req_ready,
  output logic               req_valid,
  output logic [63:0]        req_addr,
  output logic [31:0]        req_data,
  output logic [NUM_SRC-1:0] done_vec
);

  localparam logic [2:0] MMC_F = 3'(MMC);

  logic             valid_q, valid_d;
  logic [63:0]      addr_q, addr_d;
  logic [15:0]      data_q, data_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             launch, done;
  logic [2:0]       nbits;
  logic [15:0]      vec_mask, vec_off;

  assign nbits    = eff_bits(cfg.mme, MMC_F);
  assign vec_mask = (16'd1 << nbits) - 16'd1;
  assign vec_off  = 16'(pick_idx) & vec_mask;

  assign done   = valid_q & req_ready;
  assign launch = ~valid_q & cfg.en & pick_vld;

  always_comb begin
    valid_d = valid_q;
    addr_d  = addr_q;
    data_d  = data_q;
    idx_d   = idx_q;
    if (done) begin
      valid_d = 1'b0;
    end else if (launch) begin
      valid_d = 1'b1;
      addr_d  = cfg.addr;
      data_d  = cfg.data + vec_off;
      idx_d   = pick_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      idx_q   <= idx_d;
    end
  end

  always_comb begin
    done_vec = '0;
    if (done) done_vec[idx_q] = 1'b1;
  end

  assign req_valid = valid_q;
  assign req_addr  = addr_q;
  assign req_data  = {16'h0000, data_q};

endmodule

// File: rtl/msi_cap_gen.sv
module msi_cap_gen
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4,
  parameter logic [7:0]  CAP_PTR = 8'h50,
  parameter logic [7:0]  CAP_ID  = 8'h05
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_req,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_addr,
  input  logic [3:0]         cfg_be,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [NUM_SRC-1:0] irq_clr,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [63:0]        req_addr,
  output logic [31:0]        req_data,
  output logic               intx_o
);

  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int unsigned MMC   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 0;

  msi_cfg_t           cfg_q;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] done_vec;
  logic               pick_vld;
  logic [IDX_W-1:0]   pick_idx;

  msi_cfg_regs #(
    .CAP_PTR (CAP_PTR),
    .CAP_ID  (CAP_ID),
    .MMC     (MMC)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_req   (cfg_req),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cfg_o     (cfg_q)
  );

  msi_pend_arb #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W)
  ) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (irq_src),
    .clr      (irq_clr),
    .done_vec (done_vec),
    .pend_o   (pend),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx)
  );

  msi_req_gen #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W),
    .MMC     (MMC)
  ) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg_q),
    .pick_vld  (pick_vld),
    .pick_idx  (pick_idx),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .done_vec  (done_vec)
  );

  // Legacy line: level of any pending source, masked while messaging is on.
  assign intx_o = ~cfg_q.en & (|pend);

endmodule

// File: rtl/msi_cap_gen_chk.sv
module msi_cap_gen_chk #(
  parameter int unsigned NUM_SRC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [63:0]        req_addr,
  input logic [31:0]        req_data,
  input logic               intx_o,
  input logic               msi_en,
  input logic [63:0]        prog_addr,
  input logic [NUM_SRC-1:0] done_vec
);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_data)));

  p_no_msg_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(msi_en));

  p_intx_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |-> !intx_o);

  p_addr_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> (req_addr == $past(prog_addr)));

  p_one_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_vec));

  p_done_on_hs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_vec) |-> (req_valid && req_ready));

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_data[31:16] == 16'h0000));

endmodule

bind msi_cap_gen msi_cap_gen_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_data  (req_data),
  .intx_o    (intx_o),
  .msi_en    (cfg_q.en),
  .prog_addr (cfg_q.addr),
  .done_vec  (done_vec)
);

// File: tb/msi_cap_gen_tb.sv
`timescale 1ns/1ps
module msi_cap_gen_tb;

  localparam int NS = 4;

  logic          clk, rst_n;
  logic          cfg_req, cfg_we;
  logic [7:0]    cfg_addr;
  logic [3:0]    cfg_be;
  logic [31:0]   cfg_wdata, cfg_rdata;
  logic [NS-1:0] irq_src, irq_clr;
  logic          req_valid, req_ready;
  logic [63:0]   req_addr;
  logic [31:0]   req_data;
  logic          intx_o;

  int tests = 0, fails = 0;
  bit finished = 0;

  msi_cap_gen #(.NUM_SRC(NS), .CAP_PTR(8'h50), .CAP_ID(8'h05)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_src(irq_src),
    .irq_clr(irq_clr), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .intx_o(intx_o)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // {vectors-granted[2:0], data[15:0], source mask[3:0]}
  localparam logic [22:0] VEC [6] = '{
    {3'd2, 16'h4A20, 4'b1111},
    {3'd0, 16'h0100, 4'b1010},
    {3'd1, 16'h0010, 4'b1101},
    {3'd2, 16'hFFFE, 4'b0110},
    {3'd7, 16'h1234, 4'b1000},
    {3'd2, 16'h8000, 4'b0001}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_req = 1; cfg_we = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_req = 0; cfg_we = 0;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_req = 1; cfg_we = 0; cfg_addr = a;
    @(negedge clk);
    cfg_req = 0;
    d = cfg_rdata;
  endtask

  task automatic pulse_src(input logic [NS-1:0] m);
    @(negedge clk); irq_src = m;
    @(negedge clk); irq_src = '0;
  endtask

  function automatic logic [31:0] ctl(input logic en, input logic [2:0] mme);
    return {8'h00, 1'b0, mme, 3'b000, en, 16'h0000};
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] a_hold;
    logic [31:0] d_hold;
    bit          seen;
    rst_n = 0; cfg_req = 0; cfg_we = 0; cfg_addr = 0; cfg_be = 0; cfg_wdata = 0;
    irq_src = 0; irq_clr = 0; req_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R4: reset state
    @(negedge clk);
    chk("R4 req_valid", 64'(req_valid), 64'd0);
    chk("R4 intx_o", 64'(intx_o), 64'd0);
    cfg_rd(8'h54, rd); chk("R4 addr low", 64'(rd), 64'd0);
    cfg_rd(8'h58, rd); chk("R4 addr high", 64'(rd), 64'd0);
    cfg_rd(8'h5C, rd); chk("R4 data", 64'(rd), 64'd0);

    // R1 / R2: pointer, header, unimplemented offsets
    cfg_rd(8'h34, rd); chk("R1 cap pointer", 64'(rd), 64'h50);
    cfg_rd(8'h00, rd); chk("R1 unimpl 0x00", 64'(rd), 64'd0);
    cfg_rd(8'h60, rd); chk("R1 unimpl 0x60", 64'(rd), 64'd0);
    cfg_rd(8'h50, rd); chk("R2 header reset", 64'(rd), 64'h0084_0005);
    @(negedge clk); chk("R1 rdata held", 64'(cfg_rdata), 64'h0084_0005);

    // R3: byte lanes and forced-zero address bits
    cfg_wr(8'h54, 4'b0101, 32'hAABB_CCDF);
    cfg_rd(8'h54, rd); chk("R3 addr low lanes", 64'(rd), 64'h00BB_00DC);
    cfg_wr(8'h5C, 4'b1110, 32'hFFFF_5566);
    cfg_rd(8'h5C, rd); chk("R3 data lane1 only", 64'(rd), 64'h0000_5500);
    cfg_wr(8'h50, 4'b1011, 32'hFFFF_FFFF);
    cfg_rd(8'h50, rd); chk("R3 ctl ignores lanes 0,1,3", 64'(rd), 64'h0084_0005);
    cfg_wr(8'h50, 4'b0100, ctl(1'b0, 3'd2));
    cfg_rd(8'h50, rd); chk("R2 header granted=2", 64'(rd), 64'h00A4_0005);

    // Main table: R5, R6, R7, R9
    for (int i = 0; i < 6; i++) begin
      logic [2:0]  mme;
      logic [15:0] dat;
      logic [3:0]  msk;
      logic [2:0]  n;
      logic [63:0] exp_a;
      logic [15:0] exp_d [4];
      int          n_exp, got;
      mme = VEC[i][22:20]; dat = VEC[i][19:4]; msk = VEC[i][3:0];
      n = (mme > 3'd2) ? 3'd2 : mme;
      exp_a = {32'h0000_0001 + 32'(i), 32'hFEE0_1000 + 32'(i * 16)};
      cfg_wr(8'h50, 4'b0100, ctl(1'b0, mme));
      cfg_wr(8'h54, 4'hF, exp_a[31:0]);
      cfg_wr(8'h58, 4'hF, exp_a[63:32]);
      cfg_wr(8'h5C, 4'hF, {16'h0, dat});
      n_exp = 0;
      for (int k = 0; k < 4; k++) begin
        if (msk[k]) begin
          exp_d[n_exp] = dat + (16'(k) & ((16'd1 << n) - 16'd1));
          n_exp++;
        end
      end
      pulse_src(msk);
      repeat (2) @(negedge clk);
      chk($sformatf("R9 no request while disabled v%0d", i), 64'(req_valid), 64'd0);
      chk($sformatf("R9 intx while disabled v%0d", i), 64'(intx_o), 64'd1);
      cfg_wr(8'h50, 4'b0100, ctl(1'b1, mme));
      chk($sformatf("R9 intx masked v%0d", i), 64'(intx_o), 64'd0);
      got = 0;
      for (int c = 0; c < 30; c++) begin
        if (req_valid) begin
          if (got < n_exp) begin
            chk($sformatf("R5 addr v%0d", i), req_addr, exp_a);
            chk($sformatf("R7 payload v%0d #%0d", i, got), 64'(req_data), 64'(exp_d[got]));
          end
          got++;
        end
        @(negedge clk);
      end
      chk($sformatf("R6 request count v%0d", i), 64'(got), 64'(n_exp));
    end

    // R8: backpressure, higher-priority arrival behind a held request
    req_ready = 0;
    cfg_wr(8'h50, 4'b0100, ctl(1'b1, 3'd2));
    cfg_wr(8'h5C, 4'hF, 32'h0000_0200);
    pulse_src(4'b0010);
    @(negedge clk);
    chk("R8 valid raised", 64'(req_valid), 64'd1);
    a_hold = req_addr; d_hold = req_data;
    pulse_src(4'b0001);
    repeat (3) @(negedge clk);
    chk("R8 valid held", 64'(req_valid), 64'd1);
    chk("R8 addr held", req_addr, a_hold);
    chk("R8 data not replaced", 64'(req_data), 64'h0201);
    req_ready = 1;
    @(negedge clk);
    chk("R6 gap after handshake", 64'(req_valid), 64'd0);
    @(negedge clk);
    chk("R6 next source issued", 64'(req_data), 64'h0200);
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R6 no repeat", 64'(req_valid), 64'd0);

    // R10: clear while disabled
    cfg_wr(8'h50, 4'b0100, ctl(1'b0, 3'd2));
    pulse_src(4'b0100);
    chk("R10 intx before clear", 64'(intx_o), 64'd1);
    @(negedge clk); irq_clr = 4'b0100;
    @(negedge clk); irq_clr = 4'b0000;
    chk("R10 intx after clear", 64'(intx_o), 64'd0);
    cfg_wr(8'h50, 4'b0100, ctl(1'b1, 3'd2));
    seen = 0;
    repeat (5) begin
      @(negedge clk);
      if (req_valid) seen = 1;
    end
    chk("R10 cleared source silent", 64'(seen), 64'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule